// File: doc/BRIEF.md
# PHY Configuration Write Port Driven by a Control Word

A PHY keeps its internal configuration registers behind one 32-bit control word. Software does not write these registers directly. It updates the control word and toggles a strobe bit inside it. This block has two halves around that word.

The receiving half samples the word on every clock and looks for a rising edge on the strobe bit. When it sees one, it decodes a port index, a register address and a data byte from the word. It then stores the byte in a register file that has one bank for each PHY port. The write happens only if the write-enable bit is set and the active-low test-reset bit is high. A debug read port returns any entry of the register file combinationally.

The sending half accepts a single write request and produces the control-word sequence for it. It presents the word with the strobe low, then with the strobe high, then with the strobe low again. Each of the three words is held for a programmable number of cycles. A select input lets the control word come from an external source instead, so that software-style sequences can reach the receiving half directly.

Top module: `phy_cfg_port`

## Requirements
- R1: Control-word fields: bits 7:0 are the data byte, bits 15:8 the register address, and bits 18:16 the port index. A committed write stores the data byte at that address in that port's bank.
- R2: A write is committed only in the clock cycle where bit 22 is 1 and it was 0 at the previous clock sample. Holding bit 22 high, even while the other fields change, commits nothing further.
- R3: A strobe edge while bit 21 (write enable) is 0 leaves the register file unchanged.
- R4: A strobe edge whose port index is NUM_PORTS (default 2) or larger leaves every bank unchanged.
- R5: While bit 23 is 0, the whole register file is cleared and strobe edges commit nothing. Raising bit 23 while bit 22 is already high causes no write.
- R6: After a request is accepted, the sender presents three words in order: strobe low, strobe high, strobe low. Each is held for hold_i+1 cycles.
- R7: Every word the sender presents carries the request's port, address and data, with bit 21 = 1 and bit 23 = 1. All other bits are 0 apart from bit 22.
- R8: done_o is a one-cycle pulse. It rises 3*(hold_i+1) cycles after the accepting edge, at the same moment busy_o falls. Requests made while busy_o is high are ignored.
- R9: Asserting rst_ni clears the register file, returns the sender to idle and sets its word to zero.
- R10: dbg_data_o returns the stored byte of bank dbg_port_i at dbg_addr_i in the same cycle. A port index of NUM_PORTS or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request; accepted when the sender is idle |
| req_port_i | input | 3 | Port index of the request |
| req_addr_i | input | 8 | Register address of the request |
| req_data_i | input | 8 | Data byte of the request |
| hold_i | input | HOLD_W | Extra hold cycles for each word, latched at acceptance |
| busy_o | output | 1 | Sender is running a sequence |
| done_o | output | 1 | One-cycle pulse after the final word |
| ext_sel_i | input | 1 | 1: the receiving half takes ext_word_i; 0: it takes the sender's word |
| ext_word_i | input | 32 | Externally driven control word |
| ctrl_word_o | output | 32 | Control word currently seen by the receiving half |
| dbg_port_i | input | 3 | Debug read port index |
| dbg_addr_i | input | 8 | Debug read address |
| dbg_data_o | output | 8 | Debug read data |

## Verification
The assertions assume that the control word only changes on clock edges. They also assume that the strobe bit seen by the receiving half comes from a single source at a time, so a switch of ext_sel_i can itself produce an edge.

To respect both, the bench drives every input at the falling edge. It flips ext_sel_i only while the sender's word has its strobe low and the external word also has its strobe low. Sender requests are raised only while busy_o is low, except in the one case that deliberately checks that a request during busy_o is ignored.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int WORD_W   = 32;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int PORT_W   = 3;
  localparam int DATA_LSB = 0;
  localparam int ADDR_LSB = 8;
  localparam int PORT_LSB = 16;
  localparam int WEN_BIT  = 21;
  localparam int STB_BIT  = 22;
  localparam int RSTN_BIT = 23;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_SETUP,
    MS_HIGH,
    MS_LOW
  } mst_state_e;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfg_wr_t;

  function automatic logic [WORD_W-1:0] pack_word(cfg_wr_t w, logic stb);
    logic [WORD_W-1:0] r;
    r = '0;
    r[DATA_LSB +: DATA_W] = w.data;
    r[ADDR_LSB +: ADDR_W] = w.addr;
    r[PORT_LSB +: PORT_W] = w.port;
    r[WEN_BIT]  = 1'b1;
    r[RSTN_BIT] = 1'b1;
    r[STB_BIT]  = stb;
    return r;
  endfunction
endpackage

// File: rtl/phy_cfg_master.sv
module phy_cfg_master
  import phy_cfg_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  cfg_wr_t           req_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [WORD_W-1:0] word_o,
  output logic              busy_o,
  output logic              done_o
);
  mst_state_e        state_q;
  logic [HOLD_W-1:0] cnt_q, hold_q;
  cfg_wr_t           wr_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      wr_q    <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        MS_IDLE: if (req_valid_i) begin
          wr_q    <= req_i;
          hold_q  <= hold_i;
          cnt_q   <= hold_i;
          word_q  <= pack_word(req_i, 1'b0);
          state_q <= MS_SETUP;
        end
        MS_SETUP: if (cnt_zero) begin
          word_q  <= pack_word(wr_q, 1'b1);
          cnt_q   <= hold_q;
          state_q <= MS_HIGH;
        end else cnt_q <= cnt_q - 1'b1;
        MS_HIGH: if (cnt_zero) begin
          word_q  <= pack_word(wr_q, 1'b0);
          cnt_q   <= hold_q;
          state_q <= MS_LOW;
        end else cnt_q <= cnt_q - 1'b1;
        MS_LOW: if (cnt_zero) begin
          done_q  <= 1'b1;
          state_q <= MS_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign word_o = word_q;
  assign busy_o = (state_q != MS_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/phy_cfg_slave.sv
module phy_cfg_slave
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              wr_o,
  output logic [PORT_W-1:0] wr_port_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              clr_o
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(NUM_PORTS);

  logic stb_q, stb_rise, port_ok;
  logic unused_bits;

  assign unused_bits = ^{word_i[WORD_W-1:RSTN_BIT+1], word_i[WEN_BIT-1:PORT_LSB+PORT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= word_i[STB_BIT];
  end

  assign stb_rise  = word_i[STB_BIT] & ~stb_q;
  assign wr_port_o = word_i[PORT_LSB +: PORT_W];
  assign wr_addr_o = word_i[ADDR_LSB +: ADDR_W];
  assign wr_data_o = word_i[DATA_LSB +: DATA_W];
  assign port_ok   = ({1'b0, wr_port_o} < PORT_LIM);
  assign clr_o     = ~word_i[RSTN_BIT];
  assign wr_o      = stb_rise & word_i[WEN_BIT] & word_i[RSTN_BIT] & port_ok;
endmodule

// File: rtl/phy_cfg_regfile.sv
module phy_cfg_regfile
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PORT_W-1:0] rd_port_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_PORTS-1:0][DATA_W-1:0] port_rd;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              sel;

    assign sel = wr_i && (wr_port_i == PORT_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      end else if (clr_i) begin
        for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      end else if (sel) begin
        mem_q[wr_addr_i] <= wr_data_i;
      end
    end

    assign port_rd[p] = mem_q[rd_addr_i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_port_i == PORT_W'(p)) rd_data_o = port_rd[p];
  end
endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int HOLD_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              ext_sel_i,
  input  logic [WORD_W-1:0] ext_word_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  input  logic [PORT_W-1:0] dbg_port_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  cfg_wr_t           req;
  logic [WORD_W-1:0] mst_word, ctrl_word;
  logic              slv_wr, slv_clr;
  logic [PORT_W-1:0] slv_wr_port;
  logic [ADDR_W-1:0] slv_wr_addr;
  logic [DATA_W-1:0] slv_wr_data;

  assign req = '{port: req_port_i, addr: req_addr_i, data: req_data_i};

  phy_cfg_master #(.HOLD_W(HOLD_W)) i_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_i       (req),
    .hold_i      (hold_i),
    .word_o      (mst_word),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign ctrl_word   = ext_sel_i ? ext_word_i : mst_word;
  assign ctrl_word_o = ctrl_word;

  phy_cfg_slave #(.NUM_PORTS(NUM_PORTS)) i_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (ctrl_word),
    .wr_o      (slv_wr),
    .wr_port_o (slv_wr_port),
    .wr_addr_o (slv_wr_addr),
    .wr_data_o (slv_wr_data),
    .clr_o     (slv_clr)
  );

  phy_cfg_regfile #(.NUM_PORTS(NUM_PORTS)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (slv_clr),
    .wr_i      (slv_wr),
    .wr_port_i (slv_wr_port),
    .wr_addr_i (slv_wr_addr),
    .wr_data_i (slv_wr_data),
    .rd_port_i (dbg_port_i),
    .rd_addr_i (dbg_addr_i),
    .rd_data_o (dbg_data_o)
  );
endmodule

// File: rtl/phy_cfg_port_chk.sv
module phy_cfg_port_chk
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic [WORD_W-1:0] mst_word_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              wr_i,
  input logic [PORT_W-1:0] wr_port_i
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(NUM_PORTS);

  logic prev_stb_q;
  logic unused_chk;

  assign unused_chk = ^{word_i[WORD_W-1:RSTN_BIT+1], word_i[WEN_BIT-1:0],
                        mst_word_i[WORD_W-1:RSTN_BIT+1], mst_word_i[WEN_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_stb_q <= 1'b0;
    else         prev_stb_q <= word_i[STB_BIT];
  end

  // R2
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (word_i[STB_BIT] && !prev_stb_q));

  // R3
  write_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> word_i[WEN_BIT]);

  // R4
  port_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> ({1'b0, wr_port_i} < PORT_LIM));

  // R5
  test_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_i[RSTN_BIT] |-> !wr_i);

  // R7
  mst_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (mst_word_i[RSTN_BIT] && mst_word_i[WEN_BIT]));

  // R6
  strobe_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_word_i[STB_BIT] |-> busy_i);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);
endmodule

bind phy_cfg_port phy_cfg_port_chk #(.NUM_PORTS(NUM_PORTS)) i_phy_cfg_port_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_i     (ctrl_word),
  .mst_word_i (mst_word),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .wr_i       (slv_wr),
  .wr_port_i  (slv_wr_port)
);

// File: tb/test_phy_cfg_port.sv
module test_phy_cfg_port;
  import phy_cfg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 2;
  localparam int HW         = 4;
  localparam int DEPTH      = 256;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [PORT_W-1:0] req_port_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic [HW-1:0]     hold_i = '0;
  logic              busy_o, done_o;
  logic              ext_sel_i = 1'b0;
  logic [WORD_W-1:0] ext_word_i = '0;
  logic [WORD_W-1:0] ctrl_word_o;
  logic [PORT_W-1:0] dbg_port_i = '0;
  logic [ADDR_W-1:0] dbg_addr_i = '0;
  logic [DATA_W-1:0] dbg_data_o;

  logic [7:0] model [NP][DEPTH];
  int checks = 0;
  int failures = 0;

  phy_cfg_port #(.NUM_PORTS(NP), .HOLD_W(HW)) i_phy_cfg_port (
    .clk_i, .rst_ni, .req_valid_i, .req_port_i, .req_addr_i, .req_data_i,
    .hold_i, .busy_o, .done_o, .ext_sel_i, .ext_word_i, .ctrl_word_o,
    .dbg_port_i, .dbg_addr_i, .dbg_data_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [2:0] p, input logic [7:0] a,
                                          input logic [7:0] d, input logic s,
                                          input logic wen, input logic rstn);
    logic [31:0] w;
    w = '0;
    w[7:0] = d; w[15:8] = a; w[18:16] = p;
    w[21] = wen; w[22] = s; w[23] = rstn;
    return w;
  endfunction

  function automatic logic [7:0] pat(input int p, input int a);
    return 8'(a * 7 + p * 91 + 3);
  endfunction

  task automatic rd(input int p, input int a, output logic [7:0] d);
    dbg_port_i = 3'(p);
    dbg_addr_i = 8'(a);
    #1;
    d = dbg_data_o;
  endtask

  task automatic clear_model();
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++) model[p][a] = 8'h00;
  endtask

  task automatic read_all(input string req);
    logic [7:0] d;
    @(negedge clk_i);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++) begin
        rd(p, a, d);
        chk(req, {24'h0, d}, {24'h0, model[p][a]});
      end
  endtask

  // sender write with word-sequence and timing checks
  task automatic mwrite(input logic [2:0] p, input logic [7:0] a, input logic [7:0] d,
                        input logic [HW-1:0] h);
    int k;
    int bad;
    logic [31:0] bad_act, bad_exp, e;
    @(negedge clk_i);
    ext_sel_i   = 1'b0;
    req_port_i  = p; req_addr_i = a; req_data_i = d; hold_i = h;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    k = 1; bad = 0; bad_act = '0; bad_exp = '0;
    while (!done_o && k < 200) begin
      e = mk_word(p, a, d, (k >= int'(h) + 2) && (k <= 2 * int'(h) + 2), 1'b1, 1'b1);
      if (ctrl_word_o !== e && bad == 0) begin
        bad = 1; bad_act = ctrl_word_o; bad_exp = e;
      end
      @(negedge clk_i);
      k++;
    end
    // R6 R7: word sequence
    chk("R6/R7 word sequence", bad_act, bad_exp);
    // R8: done timing
    chk("R8 done latency", 32'(k - 1), 32'(3 * (int'(h) + 1)));
    chk("R8 busy low at done", {31'h0, busy_o}, 32'h0);
    if (int'(p) < NP) model[p][a] = d;
  endtask

  task automatic ext_set(input logic [31:0] w);
    @(negedge clk_i);
    ext_sel_i  = 1'b1;
    ext_word_i = w;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    clear_model();
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9 word at reset", ctrl_word_o, 32'h0);
    chk("R9 busy at reset", {31'h0, busy_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 done after reset", {31'h0, done_o}, 32'h0);
    rd(1, 200, d);
    chk("R9 regfile zero", {24'h0, d}, 32'h0);

    // R1: sweep every address of both banks through the sender
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++)
        mwrite(3'(p), 8'(a), pat(p, a), '0);
    read_all("R1/R10 sweep readback");

    // R6 R8: hold lengths
    for (int h = 1; h < 6; h++)
      mwrite(3'(h % NP), 8'(h * 17), 8'(h * 29 + 5), HW'(h));
    read_all("R1 after hold sweep");

    // R8: request during busy is ignored
    @(negedge clk_i);
    req_port_i = 3'd0; req_addr_i = 8'h01; req_data_i = 8'hC3; hold_i = 4'd3;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    req_port_i = 3'd1; req_addr_i = 8'h02; req_data_i = 8'h3C; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 40 && !done_o; i++) @(negedge clk_i);
    model[0][1] = 8'hC3;
    begin
      int dn;
      dn = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk_i);
        if (done_o) dn++;
      end
      chk("R8 no second done", 32'(dn), 32'h0);
    end
    rd(1, 2, d);
    chk("R8 busy request ignored", {24'h0, d}, {24'h0, model[1][2]});
    rd(0, 1, d);
    chk("R8 accepted request written", {24'h0, d}, {24'h0, model[0][1]});

    // R2: level-held strobe commits once
    ext_set(mk_word(3'd1, 8'h33, 8'h11, 1'b0, 1'b1, 1'b1));
    ext_set(mk_word(3'd1, 8'h33, 8'h11, 1'b1, 1'b1, 1'b1));
    ext_set(mk_word(3'd1, 8'h33, 8'h22, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk_i);
    rd(1, 8'h33, d);
    chk("R2 held strobe no rewrite", {24'h0, d}, 32'h11);
    ext_set(mk_word(3'd1, 8'h33, 8'h22, 1'b0, 1'b1, 1'b1));
    ext_set(mk_word(3'd1, 8'h33, 8'h22, 1'b1, 1'b1, 1'b1));
    @(negedge clk_i);
    rd(1, 8'h33, d);
    chk("R2 new edge commits", {24'h0, d}, 32'h22);
    model[1][8'h33] = 8'h22;

    // R3: write enable low
    ext_set(mk_word(3'd0, 8'h40, 8'h5A, 1'b0, 1'b0, 1'b1));
    ext_set(mk_word(3'd0, 8'h40, 8'h5A, 1'b1, 1'b0, 1'b1));
    @(negedge clk_i);
    rd(0, 8'h40, d);
    chk("R3 wen low ignored", {24'h0, d}, {24'h0, model[0][8'h40]});

    // R4: out-of-range ports
    for (int q = NP; q < 8; q++) begin
      ext_set(mk_word(3'(q), 8'h10, 8'hEE, 1'b0, 1'b1, 1'b1));
      ext_set(mk_word(3'(q), 8'h10, 8'hEE, 1'b1, 1'b1, 1'b1));
      @(negedge clk_i);
      for (int p = 0; p < NP; p++) begin
        rd(p, 8'h10, d);
        chk("R4 bad port no write", {24'h0, d}, {24'h0, model[p][8'h10]});
      end
      rd(q, 8'h10, d);
      chk("R10 bad port reads zero", {24'h0, d}, 32'h0);
    end
    ext_set(mk_word(3'd0, 8'h10, 8'hEE, 1'b0, 1'b1, 1'b1));

    // R5: test reset low clears, strobe ignored, no edge on release
    ext_set(mk_word(3'd0, 8'h05, 8'h77, 1'b0, 1'b1, 1'b0));
    ext_set(mk_word(3'd0, 8'h05, 8'h77, 1'b1, 1'b1, 1'b0));
    ext_set(mk_word(3'd0, 8'h05, 8'h77, 1'b1, 1'b1, 1'b1));
    ext_set(mk_word(3'd0, 8'h05, 8'h77, 1'b0, 1'b1, 1'b1));
    clear_model();
    read_all("R5 clear and ignore");

    // sender works again after clear
    mwrite(3'd1, 8'hA5, 8'h96, 4'd2);
    rd(1, 8'hA5, d);
    chk("R1 write after clear", {24'h0, d}, 32'h96);

    // R9: asynchronous reset mid-sequence
    @(negedge clk_i);
    req_port_i = 3'd0; req_addr_i = 8'h07; req_data_i = 8'h44; hold_i = 4'd4;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 busy cleared", {31'h0, busy_o}, 32'h0);
    chk("R9 word cleared", ctrl_word_o, 32'h0);
    rd(1, 8'hA5, d);
    chk("R9 regfile cleared", {24'h0, d}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_model();
    read_all("R9 regfile after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule